// File: doc/BRIEF.md
# Weighted Degradation Score Tracker

This block keeps a running health figure for a repetitive mechanical tool. An upstream stage classifies every work cycle (one stitch) as either normal or degraded and presents that verdict with a one-cycle strobe. On each strobe the tracker moves a cumulative degradation score. A normal verdict lowers the score by one, and the score never goes below zero. A degraded verdict raises the score by two when the stitch before it was normal, or by three when the stitch before it was also degraded. This makes a run of degraded stitches count for more than the same number of isolated ones.

The score is compared with a critical level that the surrounding system supplies. The level is found by experiment and can change at run time. An alarm output is high whenever the score has reached that level. The score is registered and changes only on the clock edge that samples a strobe. The alarm is derived from the registered score and the current critical level without a further register.

Top module: `degr_score_tracker`

## Requirements
- R1: During and after a synchronous active-high reset the score is 0, and the remembered previous class is normal.
- R2: A strobed normal verdict (`verdict_bad` = 0) lowers the score by exactly 1, whether the previous stitch was normal or degraded.
- R3: A strobed normal verdict while the score is 0 leaves the score at 0.
- R4: A strobed degraded verdict (`verdict_bad` = 1) whose previous stitch was normal raises the score by 2. This includes the first degraded verdict after reset.
- R5: A strobed degraded verdict whose previous stitch was also degraded raises the score by 3.
- R6: A degraded increment that would pass 65535 leaves the score at 65535 instead of wrapping.
- R7: With `verdict_vld` low, the score and the remembered previous class hold, whatever `verdict_bad` carries.
- R8: `alarm` is 1 exactly when the score is greater than or equal to `crit_lvl`. It follows a change of `crit_lvl` in the same cycle.
- R9: The score shows the effect of a strobe one clock edge after the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| verdict_vld | input | 1 | One-cycle strobe: a stitch verdict is present |
| verdict_bad | input | 1 | Verdict class: 1 = degraded, 0 = normal |
| crit_lvl | input | 16 | Critical score level for the alarm |
| score | output | 16 | Current degradation score |
| alarm | output | 1 | High while score >= crit_lvl |

## Verification
The bench runs the score down onto the zero floor with repeated normal verdicts. A design with no floor would wrap to 65535 there and raise the alarm at once. It alternates and chains degraded verdicts so that the +2 and +3 steps and the first degraded stitch after reset are each checked. A tracker that keyed the weight on the current verdict alone, or that reset the previous class to degraded, gives the wrong step. It drives the score to the top with long degraded runs to catch a wrap to a small value. It also holds `verdict_bad` high with no strobe, then sends a strobed degraded verdict, to expose a previous-class register that loads without a strobe. The critical level is swept across the score, including equality, so that a strict comparison or a registered alarm that lags a cycle is reported.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef enum logic {
    CLS_OK  = 1'b0,
    CLS_BAD = 1'b1
  } stitch_cls_e;
endpackage

// File: rtl/dst_weight_sel.sv
module dst_weight_sel
  import dst_pkg::*;
#(
  parameter int SCORE_W    = 16,
  parameter int DEC_STEP   = 1,
  parameter int INC_AFTER_OK  = 2,
  parameter int INC_AFTER_BAD = 3
) (
  input  stitch_cls_e        prev_cls,
  input  stitch_cls_e        cur_cls,
  output logic               step_up,
  output logic [SCORE_W-1:0] step_amt
);
  localparam logic [SCORE_W-1:0] DEC_V   = SCORE_W'(DEC_STEP);
  localparam logic [SCORE_W-1:0] INC_OK_V  = SCORE_W'(INC_AFTER_OK);
  localparam logic [SCORE_W-1:0] INC_BAD_V = SCORE_W'(INC_AFTER_BAD);

  always_comb begin
    step_up  = (cur_cls == CLS_BAD);
    step_amt = DEC_V;
    if (cur_cls == CLS_BAD) begin
      step_amt = (prev_cls == CLS_BAD) ? INC_BAD_V : INC_OK_V;
    end
  end
endmodule

// File: rtl/dst_score_acc.sv
module dst_score_acc #(
  parameter int SCORE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic               step_up,
  input  logic [SCORE_W-1:0] step_amt,
  output logic [SCORE_W-1:0] score_q
);
  localparam logic [SCORE_W-1:0] TOP_V = {SCORE_W{1'b1}};

  logic [SCORE_W:0]   sum_ext;
  logic [SCORE_W-1:0] score_d;

  always_comb begin
    sum_ext = {1'b0, score_q} + {1'b0, step_amt};
    if (step_up) begin
      score_d = sum_ext[SCORE_W] ? TOP_V : sum_ext[SCORE_W-1:0];
    end else begin
      score_d = (score_q > step_amt) ? (score_q - step_amt) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score_q <= '0;
    end else if (upd_en) begin
      score_q <= score_d;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> score_q == '0);
  // R3
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !step_up && score_q == '0) |=> score_q == '0);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(score_q));
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && step_up) |=> score_q >= $past(score_q));
endmodule

// File: rtl/dst_alarm_cmp.sv
module dst_alarm_cmp #(
  parameter int SCORE_W = 16
) (
  input  logic [SCORE_W-1:0] score,
  input  logic [SCORE_W-1:0] crit,
  output logic               hit
);
  always_comb hit = (score >= crit);
endmodule

// File: rtl/degr_score_tracker.sv
module degr_score_tracker
  import dst_pkg::*;
#(
  parameter int SCORE_W       = 16,
  parameter int DEC_STEP      = 1,
  parameter int INC_AFTER_OK  = 2,
  parameter int INC_AFTER_BAD = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               verdict_vld,
  input  logic               verdict_bad,
  input  logic [SCORE_W-1:0] crit_lvl,
  output logic [SCORE_W-1:0] score,
  output logic               alarm
);
  stitch_cls_e        prev_q;
  stitch_cls_e        cur_cls;
  logic               step_up;
  logic [SCORE_W-1:0] step_amt;

  assign cur_cls = verdict_bad ? CLS_BAD : CLS_OK;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= CLS_OK;
    end else if (verdict_vld) begin
      prev_q <= cur_cls;
    end
  end

  dst_weight_sel #(
    .SCORE_W(SCORE_W), .DEC_STEP(DEC_STEP),
    .INC_AFTER_OK(INC_AFTER_OK), .INC_AFTER_BAD(INC_AFTER_BAD)
  ) u_wsel (
    .prev_cls(prev_q), .cur_cls(cur_cls),
    .step_up(step_up), .step_amt(step_amt)
  );

  dst_score_acc #(.SCORE_W(SCORE_W)) u_acc (
    .clk(clk), .rst(rst), .upd_en(verdict_vld),
    .step_up(step_up), .step_amt(step_amt), .score_q(score)
  );

  dst_alarm_cmp #(.SCORE_W(SCORE_W)) u_cmp (
    .score(score), .crit(crit_lvl), .hit(alarm)
  );

  // R2
  dec_one_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_vld && !verdict_bad && score != '0) |=> score == $past(score) - 1'b1);
  // R5
  bad_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_vld && verdict_bad && prev_q == CLS_BAD && score < 16'd100)
    |=> score == $past(score) + 16'd3);
  // R4
  ok_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (verdict_vld && verdict_bad && prev_q == CLS_OK && score < 16'd100)
    |=> score == $past(score) + 16'd2);
  // R7
  prev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !verdict_vld |=> $stable(prev_q));
endmodule

// File: tb/degr_score_tracker_tb.sv
module degr_score_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         verdict_vld;
  logic         verdict_bad;
  logic [W-1:0] crit_lvl;
  logic [W-1:0] score;
  logic         alarm;

  int checks = 0;
  int errors = 0;
  int   exp_score;
  logic exp_prev;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  degr_score_tracker u_dut (
    .clk(clk), .rst(rst), .verdict_vld(verdict_vld), .verdict_bad(verdict_bad),
    .crit_lvl(crit_lvl), .score(score), .alarm(alarm)
  );

  function automatic int model_next(int s, logic prev, logic bad);
    int n;
    if (!bad) n = (s > 0) ? s - 1 : 0;
    else begin
      n = s + (prev ? 3 : 2);
      if (n > 65535) n = 65535;
    end
    return n;
  endfunction

  task automatic check(string tag);
    checks++;
    if (score !== W'(exp_score)) begin
      errors++;
      $display("FAIL %s score actual %0d expected %0d", tag, score, exp_score);
    end
    checks++;
    if (alarm !== (exp_score >= int'(crit_lvl))) begin
      errors++;
      $display("FAIL R8 (%s) alarm actual %0b expected %0b crit %0d",
               tag, alarm, exp_score >= int'(crit_lvl), crit_lvl);
    end
  endtask

  // called at a negedge; applies stimulus for one cycle and checks at next negedge
  task automatic step(logic v, logic b, string tag);
    verdict_vld = v;
    verdict_bad = b;
    @(posedge clk);
    if (v) begin
      exp_score = model_next(exp_score, exp_prev, b);
      exp_prev  = b;
    end
    @(negedge clk);
    verdict_vld = 1'b0;
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    verdict_vld = 1'b0;
    verdict_bad = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp_score = 0;
    exp_prev  = 1'b0;
    check("R1");
    rst = 1'b0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    crit_lvl = 16'd10;
    exp_score = 0;
    exp_prev = 1'b0;
    @(negedge clk);
    do_reset();

    // R3 floor at zero
    step(1, 0, "R3");
    step(1, 0, "R3");
    // R4 first degraded after reset adds 2
    step(1, 1, "R4");
    // R5 chained degraded adds 3
    step(1, 1, "R5");
    step(1, 1, "R5");
    // R2 normal after degraded subtracts 1
    step(1, 0, "R2");
    step(1, 0, "R2");
    // R4 degraded after normal adds 2
    step(1, 1, "R4");
    // R7 idle with bad held high, then degraded after normal must still be +2
    step(0, 1, "R7");
    step(0, 1, "R7");
    step(1, 0, "R2");
    step(0, 1, "R7");
    step(1, 1, "R4");

    // R8 sweep critical level around the score; alarm follows same cycle
    for (int d = -2; d <= 2; d++) begin
      crit_lvl = W'(exp_score + d);
      #1;
      check("R8");
    end
    crit_lvl = 16'd0;
    #1;
    check("R8");

    // R9 / R1 reset mid-run clears score and previous class
    do_reset();
    step(1, 1, "R9");
    step(1, 1, "R5");
    do_reset();
    step(1, 1, "R4");

    // R6 climb to the top with long degraded runs
    crit_lvl = 16'hFFFF;
    for (int i = 0; i < 22000; i++) begin
      verdict_vld = 1'b1;
      verdict_bad = 1'b1;
      @(posedge clk);
      exp_score = model_next(exp_score, exp_prev, 1'b1);
      exp_prev = 1'b1;
      @(negedge clk);
      if (exp_score > 65500) check("R6");
    end
    step(1, 1, "R6");
    step(1, 0, "R2");
    step(1, 1, "R6");
    step(1, 1, "R6");

    // random mix with fixed seed
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic v;
      logic b;
      v = ($urandom % 4) != 0;
      b = ($urandom % 100) < ((i / 400) * 10 + 20);
      if (i % 97 == 0) crit_lvl = W'($urandom % 200);
      step(v, b, !v ? "R7" : (!b ? "R2" : (exp_prev ? "R5" : "R4")));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule